// File: doc/BRIEF.md
# EEPROM Page Write and Completion Poll Sequencer

This block sits on the host side of an asynchronous byte-wide EEPROM bus. It is protected by a software write lock. When a start command arrives, it writes the three-step unlock prefix. It then pulls between 1 and 128 bytes from a local buffer through a request/valid handshake. It writes each byte into one page of the memory and then reads status until the internal programming has finished. All bus timing comes from the system clock, with each phase length set in cycles by a parameter.

Completion is found in one of two ways. In polling mode, bit 7 of the last written location reads as the complement of the written value until programming ends. In toggle mode, bit 6 changes on every read while programming is running. Between byte loads the memory allows only a limited time before it starts programming on its own. If the buffer cannot supply the next byte within that window, the sequencer stops loading and begins polling at once. A timeout ends the polling with an error.

Top module: `eepw_top`

## Requirements
- R1: After reset and between operations, `memCsN`, `memOeN` and `memWeN` are high, and `fetchReq`, `done` and `error` are low.
- R2: Every operation begins with three writes and no other bus cycle between them. They are, in order: 0xAA to address 0x5555, 0x55 to address 0x2AAA, and 0xA0 to address 0x5555. The address bits above bit 14 are zero for all three.
- R3: The operation writes `byteCount`+1 data bytes, so 0 means one byte and 127 means 128 bytes. Byte i goes to address {`pageSel`, i}, with i in the low 7 address bits. Its data is the `fetchData` value that was sampled with `fetchValid` high while `fetchReq` was high and `fetchIdx` equalled i.
- R4: `memWeN` is low only while `memCsN` is low, `memOeN` is high and `memDoe` is high. Each low pulse lasts at least WE_LOW_CYC cycles. The high time between two pulses is at least WE_HIGH_CYC cycles.
- R5: `memAddr` and `memDout` stay constant from the falling edge of `memWeN` through the cycle in which it rises again.
- R6: Within one operation, two falling edges of `memWeN` are fewer than LOAD_LIMIT cycles apart. If the next byte is not valid before that limit, loading stops and polling starts on the last byte already written.
- R7: When `toggleMode` was 0 at start, each status read drives the address of the last written byte. During the read, `memCsN` and `memOeN` are low, `memWeN` is high and `memDoe` is low, for READ_CYC cycles. The operation completes on the first read whose bit 7 equals bit 7 of that byte.
- R8: When `toggleMode` was 1 at start, the operation completes on the first read whose bit 6 equals bit 6 of the read just before it. In both modes `memOeN` is high for at least OE_HIGH_CYC cycles before every status read.
- R9: If completion is not seen within TIMEOUT_CYC cycles of the start of polling, `error` pulses, `done` stays low and the block returns to idle. `done` and `error` are single-cycle pulses and never occur together.
- R10: `pageSel`, `byteCount` and `toggleMode` are sampled only in the cycle `start` is accepted. Later changes to them have no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| pageSel | input | ADDR_W-7 | Page number, upper address bits |
| byteCount | input | 7 | Number of bytes minus one |
| toggleMode | input | 1 | 0: bit-7 polling, 1: bit-6 toggle detection |
| fetchReq | output | 1 | Request for the buffer byte at `fetchIdx` |
| fetchIdx | output | 7 | Index of the requested byte |
| fetchValid | input | 1 | Buffer byte valid this cycle |
| fetchData | input | 8 | Buffer byte |
| memAddr | output | ADDR_W | Memory address |
| memDout | output | 8 | Write data to the memory |
| memDoe | output | 1 | Write data drive enable |
| memDin | input | 8 | Read data from the memory |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| error | output | 1 | Timeout pulse |

## Verification
The assertions take for granted three things about the environment. `start` is raised only while the block is idle. `fetchValid` is raised only in answer to `fetchReq`. `memDin` holds steady while a status read is in progress. The bench meets these assumptions as follows. It starts a new command only after `done` or `error`. It drives the buffer handshake from the request and the index, after a random delay kept well below the load window. Its memory model changes the read data only when `memOeN` falls.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_WLOW, S_WHIGH, S_FETCH, S_RGAP, S_RREAD, S_DONE, S_FAIL
  } state_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;        // capture command inputs
    logic busCs;       // chip select active
    logic busWe;       // write enable active
    logic busOe;       // output enable active
    logic busDrive;    // drive write data and write address
    logic nextCmd;     // step to next unlock word
    logic enterData;   // unlock done, data phase begins
    logic recordLast;  // remember address and data just written
    logic nextByte;    // step buffer index
    logic latchByte;   // capture fetched byte
    logic pollStart;   // clear toggle history
    logic capture;     // store bit 6 of a status read
  } strobe_t;

endpackage

// File: rtl/eepw_ctrl.sv
module eepw_ctrl
  import eepw_pkg::*;
#(
  parameter int WE_LOW_CYC  = 12,
  parameter int WE_HIGH_CYC = 6,
  parameter int LOAD_LIMIT  = 14000,
  parameter int OE_HIGH_CYC = 16,
  parameter int READ_CYC    = 25,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    fetchValid,
  input  logic    inCmd,
  input  logic    cmdLast,
  input  logic    lastByte,
  input  logic    statusOk,
  output strobe_t st,
  output logic    fetchReq,
  output logic    busy,
  output logic    done,
  output logic    error
);
  localparam int M1     = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
  localparam int M2     = (OE_HIGH_CYC > READ_CYC) ? OE_HIGH_CYC : READ_CYC;
  localparam int PH_MAX = (M1 > M2) ? M1 : M2;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int GAP_W  = $clog2(LOAD_LIMIT + 1);
  localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);

  state_t           state, nxt;
  logic [PH_W-1:0]  phCnt;
  logic [GAP_W-1:0] gapCnt;
  logic [TO_W-1:0]  waitCnt;

  logic lowEnd, highEnd, gapEnd, readEnd, gapOut, timedOut;
  assign lowEnd   = phCnt == PH_W'(WE_LOW_CYC - 1);
  assign highEnd  = phCnt == PH_W'(WE_HIGH_CYC - 1);
  assign gapEnd   = phCnt == PH_W'(OE_HIGH_CYC - 1);
  assign readEnd  = phCnt == PH_W'(READ_CYC - 1);
  assign gapOut   = gapCnt >= GAP_W'(LOAD_LIMIT - 1);
  assign timedOut = waitCnt >= TO_W'(TIMEOUT_CYC - 1);

  always_comb begin
    st  = '0;
    nxt = state;
    unique case (state)
      S_IDLE: if (start) begin st.load = 1'b1; nxt = S_WLOW; end
      S_WLOW: begin
        st.busCs = 1'b1; st.busWe = 1'b1; st.busDrive = 1'b1;
        if (lowEnd) nxt = S_WHIGH;
      end
      S_WHIGH: begin
        st.busCs = 1'b1; st.busDrive = 1'b1;
        if (highEnd) begin
          if (inCmd) begin
            if (cmdLast) begin st.enterData = 1'b1; nxt = S_FETCH; end
            else begin st.nextCmd = 1'b1; nxt = S_WLOW; end
          end else begin
            st.recordLast = 1'b1;
            if (lastByte) begin st.pollStart = 1'b1; nxt = S_RGAP; end
            else begin st.nextByte = 1'b1; nxt = S_FETCH; end
          end
        end
      end
      S_FETCH: begin
        // window nearly gone: abandon the load and poll what was written
        if (gapOut) begin st.pollStart = 1'b1; nxt = S_RGAP; end
        else if (fetchValid) begin st.latchByte = 1'b1; nxt = S_WLOW; end
      end
      S_RGAP: begin
        if (gapEnd) nxt = S_RREAD;
        if (timedOut) nxt = S_FAIL;
      end
      S_RREAD: begin
        st.busCs = 1'b1; st.busOe = 1'b1;
        if (readEnd) begin
          if (statusOk) nxt = S_DONE;
          else begin st.capture = 1'b1; nxt = S_RGAP; end
        end
        if (timedOut && nxt != S_DONE) nxt = S_FAIL;
      end
      S_DONE:  nxt = S_IDLE;
      S_FAIL:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phCnt   <= '0;
      gapCnt  <= '0;
      waitCnt <= '0;
    end else begin
      state   <= nxt;
      phCnt   <= (nxt != state) ? '0 : phCnt + 1'b1;
      if (nxt == S_WLOW && state != S_WLOW) gapCnt <= '0;
      else if (!gapOut) gapCnt <= gapCnt + 1'b1;
      waitCnt <= (state == S_RGAP || state == S_RREAD) ? waitCnt + 1'b1 : '0;
    end
  end

  assign fetchReq = state == S_FETCH;
  assign busy     = state != S_IDLE;
  assign done     = state == S_DONE;
  assign error    = state == S_FAIL;
endmodule

// File: rtl/eepw_dpath.sv
module eepw_dpath
  import eepw_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              st,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] pageSel,
  input  logic [$clog2(PAGE_BYTES)-1:0]        byteCount,
  input  logic                 toggleMode,
  input  logic [7:0]           fetchData,
  input  logic [7:0]           memDin,
  output logic [$clog2(PAGE_BYTES)-1:0]        fetchIdx,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [7:0]           memDout,
  output logic                 memDoe,
  output logic                 memCsN,
  output logic                 memOeN,
  output logic                 memWeN,
  output logic                 inCmd,
  output logic                 cmdLast,
  output logic                 lastByte,
  output logic                 statusOk
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(15'h5555);
  localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(15'h2AAA);

  logic [PAGE_W-1:0] pageR;
  logic [OFF_W-1:0]  lastIdxR, idx;
  logic              modeR, dataPhase, prevB6, havePrev;
  logic [1:0]        cmdIdx;
  logic [7:0]        byteR, lastData, cmdData;
  logic [ADDR_W-1:0] lastAddr, cmdAddr, curAddr;

  always_comb begin
    unique case (cmdIdx)
      2'd0:    begin cmdAddr = KEY_A; cmdData = 8'hAA; end
      2'd1:    begin cmdAddr = KEY_B; cmdData = 8'h55; end
      default: begin cmdAddr = KEY_A; cmdData = 8'hA0; end
    endcase
  end

  assign curAddr = dataPhase ? {pageR, idx} : cmdAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageR <= '0; lastIdxR <= '0; modeR <= 1'b0; idx <= '0;
      cmdIdx <= '0; dataPhase <= 1'b0; byteR <= '0;
      lastAddr <= '0; lastData <= '0; prevB6 <= 1'b0; havePrev <= 1'b0;
    end else begin
      if (st.load) begin
        pageR <= pageSel; lastIdxR <= byteCount; modeR <= toggleMode;
        idx <= '0; cmdIdx <= '0; dataPhase <= 1'b0;
      end
      if (st.nextCmd)    cmdIdx <= cmdIdx + 1'b1;
      if (st.enterData)  dataPhase <= 1'b1;
      if (st.latchByte)  byteR <= fetchData;
      if (st.recordLast) begin lastAddr <= curAddr; lastData <= byteR; end
      if (st.nextByte)   idx <= idx + 1'b1;
      if (st.pollStart)  havePrev <= 1'b0;
      if (st.capture)    begin prevB6 <= memDin[6]; havePrev <= 1'b1; end
    end
  end

  logic unusedLowBits;
  assign unusedLowBits = ^memDin[5:0];

  assign statusOk = modeR ? (havePrev && memDin[6] == prevB6)
                          : (memDin[7] == lastData[7]);
  assign memAddr  = st.busDrive ? curAddr : lastAddr;
  assign memDout  = dataPhase ? byteR : cmdData;
  assign memDoe   = st.busDrive;
  assign memCsN   = ~st.busCs;
  assign memOeN   = ~st.busOe;
  assign memWeN   = ~st.busWe;
  assign fetchIdx = idx;
  assign inCmd    = ~dataPhase;
  assign cmdLast  = cmdIdx == 2'd2;
  assign lastByte = idx == lastIdxR;
endmodule

// File: rtl/eepw_top.sv
module eepw_top
  import eepw_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int PAGE_BYTES  = 128,
  parameter int WE_LOW_CYC  = 12,
  parameter int WE_HIGH_CYC = 6,
  parameter int LOAD_LIMIT  = 14000,
  parameter int OE_HIGH_CYC = 16,
  parameter int READ_CYC    = 25,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] pageSel,
  input  logic [$clog2(PAGE_BYTES)-1:0]        byteCount,
  input  logic                 toggleMode,
  output logic                 fetchReq,
  output logic [$clog2(PAGE_BYTES)-1:0]        fetchIdx,
  input  logic                 fetchValid,
  input  logic [7:0]           fetchData,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [7:0]           memDout,
  output logic                 memDoe,
  input  logic [7:0]           memDin,
  output logic                 memCsN,
  output logic                 memOeN,
  output logic                 memWeN,
  output logic                 busy,
  output logic                 done,
  output logic                 error
);
  strobe_t st;
  logic inCmd, cmdLast, lastByte, statusOk;

  eepw_ctrl #(
    .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC), .LOAD_LIMIT(LOAD_LIMIT),
    .OE_HIGH_CYC(OE_HIGH_CYC), .READ_CYC(READ_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .fetchValid(fetchValid),
    .inCmd(inCmd), .cmdLast(cmdLast), .lastByte(lastByte), .statusOk(statusOk),
    .st(st), .fetchReq(fetchReq), .busy(busy), .done(done), .error(error)
  );

  eepw_dpath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) uDpath (
    .clk(clk), .rstN(rstN), .st(st), .pageSel(pageSel), .byteCount(byteCount),
    .toggleMode(toggleMode), .fetchData(fetchData), .memDin(memDin),
    .fetchIdx(fetchIdx), .memAddr(memAddr), .memDout(memDout), .memDoe(memDoe),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .inCmd(inCmd),
    .cmdLast(cmdLast), .lastByte(lastByte), .statusOk(statusOk)
  );
endmodule

// File: rtl/eepw_chk.sv
module eepw_chk #(
  parameter int ADDR_W      = 17,
  parameter int WE_LOW_CYC  = 12,
  parameter int LOAD_LIMIT  = 14000,
  parameter int OE_HIGH_CYC = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memCsN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDoe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        memDout,
  input logic              busy,
  input logic              done,
  input logic              error
);
  logic [31:0] weLowCnt, oeHighCnt, sinceFall;
  logic        prevWe, armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weLowCnt <= '0; oeHighCnt <= '0; sinceFall <= '0; prevWe <= 1'b1; armed <= 1'b0;
    end else begin
      weLowCnt  <= memWeN ? '0 : weLowCnt + 1;
      oeHighCnt <= memOeN ? oeHighCnt + 1 : '0;
      prevWe    <= memWeN;
      sinceFall <= (!memWeN && prevWe) ? 32'd1 : sinceFall + 1;
      if (!busy) armed <= 1'b0;
      else if (!memWeN && prevWe) armed <= 1'b1;
    end
  end

  AST_WRITE_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCsN && memOeN && memDoe)); // R4
  AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> weLowCnt >= WE_LOW_CYC); // R4
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && !$past(memWeN)) |-> ($stable(memAddr) && $stable(memDout))); // R5
  AST_RISE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> ($stable(memAddr) && $stable(memDout))); // R5
  AST_LOAD_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memWeN) && armed) |-> sinceFall < LOAD_LIMIT); // R6
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (!memDoe && memWeN && !memCsN)); // R7
  AST_OE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memOeN) |-> oeHighCnt >= OE_HIGH_CYC); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
endmodule

bind eepw_top eepw_chk #(
  .ADDR_W(ADDR_W), .WE_LOW_CYC(WE_LOW_CYC), .LOAD_LIMIT(LOAD_LIMIT), .OE_HIGH_CYC(OE_HIGH_CYC)
) uChk (
  .clk(clk), .rstN(rstN), .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN),
  .memDoe(memDoe), .memAddr(memAddr), .memDout(memDout), .busy(busy),
  .done(done), .error(error)
);

// File: tb/tb_eepw_top.sv
module tb_eepw_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 17, WE_LOW = 3, WE_HIGH = 2, LOAD_LIM = 40;
  localparam int OE_HIGH = 2, READ_C = 3, TIMEOUT = 2000;
  localparam int NEVER = 1000000;

  logic clk = 0, rstN = 0, start = 0, toggleMode = 0, fetchValid = 0;
  logic [9:0] pageSel = 0;
  logic [6:0] byteCount = 0, fetchIdx;
  logic [7:0] fetchData = 0, memDin = 0, memDout;
  logic [ADDR_W-1:0] memAddr;
  logic fetchReq, memDoe, memCsN, memOeN, memWeN, busy, done, error;

  always #(CLK_PERIOD/2) clk = ~clk;

  eepw_top #(.WE_LOW_CYC(WE_LOW), .WE_HIGH_CYC(WE_HIGH), .LOAD_LIMIT(LOAD_LIM),
             .OE_HIGH_CYC(OE_HIGH), .READ_CYC(READ_C), .TIMEOUT_CYC(TIMEOUT)) dut (
    .clk(clk), .rstN(rstN), .start(start), .pageSel(pageSel), .byteCount(byteCount),
    .toggleMode(toggleMode), .fetchReq(fetchReq), .fetchIdx(fetchIdx),
    .fetchValid(fetchValid), .fetchData(fetchData), .memAddr(memAddr),
    .memDout(memDout), .memDoe(memDoe), .memDin(memDin), .memCsN(memCsN),
    .memOeN(memOeN), .memWeN(memWeN), .busy(busy), .done(done), .error(error));

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] bufMem [128];
  int stallAt = -1, maxDly = 0, stallCnt = 0, curDly = 0;

  // bench-side record of bus activity
  logic [ADDR_W-1:0] wA [140];
  logic [7:0] wD [140];
  int nW, reads, minWeLow, minWeHigh, maxFallGap, minOeHigh, holdBad, shapeBad, rdAddrBad;
  int weLowRun, weHighRun, oeHighRun, sinceFall, lastRiseCyc, busyLeft;
  bit fallSeen, prevWe = 1, prevOe = 1, tog;
  logic [ADDR_W-1:0] latchA, expAddr;
  logic [7:0] latchD, lastWData;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic int expReads(input bit tgl, input int busyN, input logic [7:0] d);
    bit t = 0, pv = 0, hv = 0, v;
    if (!tgl) return busyN + 1;
    for (int k = 1; k < busyN + 3; k++) begin
      if (k <= busyN) begin t = ~t; v = t; end else v = d[6];
      if (hv && v == pv) return k;
      pv = v; hv = 1;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // buffer responder
  always @(negedge clk) begin
    if (fetchReq) begin
      if (stallAt >= 0 && int'(fetchIdx) >= stallAt) fetchValid = 0;
      else if (stallCnt >= curDly) begin fetchValid = 1; fetchData = bufMem[fetchIdx]; end
      else begin stallCnt++; fetchValid = 0; end
    end else begin
      fetchValid = 0; stallCnt = 0; curDly = $urandom_range(0, maxDly);
    end
  end

  // bus monitor and memory model
  always @(negedge clk) if (rstN) begin
    sinceFall++;
    if (!memWeN) begin
      weLowRun++;
      if (prevWe) begin
        if (fallSeen && sinceFall > maxFallGap) maxFallGap = sinceFall;
        if (fallSeen && weHighRun < minWeHigh) minWeHigh = weHighRun;
        fallSeen = 1; sinceFall = 0; latchA = memAddr; latchD = memDout;
      end else if (memAddr != latchA || memDout != latchD) holdBad++;
      if (memCsN || !memOeN || !memDoe) shapeBad++;
      weHighRun = 0;
    end else begin
      if (!prevWe) begin
        if (memAddr != latchA || memDout != latchD) holdBad++;
        if (weLowRun < minWeLow) minWeLow = weLowRun;
        if (nW < 140) begin wA[nW] = memAddr; wD[nW] = memDout; end
        nW++; lastWData = memDout; weLowRun = 0; lastRiseCyc = cyc;
      end
      weHighRun++;
    end
    if (!memOeN && prevOe) begin
      reads++;
      if (oeHighRun < minOeHigh) minOeHigh = oeHighRun;
      if (memAddr != expAddr || memCsN || !memWeN) rdAddrBad++;
      if (busyLeft > 0) begin
        tog = ~tog; busyLeft--;
        memDin = {~lastWData[7], tog, lastWData[5:0]};
      end else memDin = lastWData;
    end
    oeHighRun = memOeN ? oeHighRun + 1 : 0;
    prevWe = memWeN; prevOe = memOeN;
  end

  task automatic runOp(input logic [9:0] pg, input int cnt, input bit tgl,
                       input int busyN, input int stall, input int dly);
    int nData = (stall >= 0) ? stall : cnt;
    bit sawDone = 0, sawErr = 0;
    int endCyc = 0, bad = 0;
    for (int i = 0; i < 128; i++) bufMem[i] = 8'($urandom);
    nW = 0; reads = 0; minWeLow = 999; minWeHigh = 999; maxFallGap = 0; minOeHigh = 999;
    holdBad = 0; shapeBad = 0; rdAddrBad = 0; fallSeen = 0; busyLeft = busyN; tog = 0;
    weHighRun = 0; weLowRun = 0;
    stallAt = stall; maxDly = dly;
    expAddr = {pg, 7'(nData - 1)};
    @(negedge clk);
    start = 1; pageSel = pg; byteCount = 7'(cnt - 1); toggleMode = tgl;
    @(negedge clk);
    start = 0; pageSel = 10'($urandom); byteCount = 7'($urandom); toggleMode = ~tgl; // R10 disturb
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (done || error) begin sawDone = done; sawErr = error; endCyc = cyc; break; end
    end
    if (busyN >= NEVER) begin
      check(sawErr && !sawDone, "R9 timeout raises error only", {sawErr, sawDone}, 2);
      check(endCyc - lastRiseCyc >= TIMEOUT, "R9 timeout not early", endCyc - lastRiseCyc, TIMEOUT);
    end else begin
      check(sawDone && !sawErr, tgl ? "R8 toggle completion" : "R7 poll completion", {sawDone, sawErr}, 2);
      check(reads == expReads(tgl, busyN, bufMem[nData-1]), tgl ? "R8 status read count" : "R7 status read count",
            reads, expReads(tgl, busyN, bufMem[nData-1]));
    end
    check(nW == 3 + nData, stall >= 0 ? "R6 write count after short load" : "R3 write count", nW, 3 + nData);
    bad = 0;
    if (nW >= 3) begin
      if (wA[0] != 17'h05555 || wD[0] != 8'hAA) bad++;
      if (wA[1] != 17'h02AAA || wD[1] != 8'h55) bad++;
      if (wA[2] != 17'h05555 || wD[2] != 8'hA0) bad++;
    end else bad = 3;
    check(bad == 0, "R2 unlock prefix", bad, 0);
    bad = 0;
    for (int i = 0; i < nData && i + 3 < 140 && i + 3 < nW; i++)
      if (wA[i+3] != {pg, 7'(i)} || wD[i+3] != bufMem[i]) bad++;
    check(bad == 0, "R3 R10 data bytes, page and order", bad, 0);
    check(shapeBad == 0 && minWeLow >= WE_LOW && minWeHigh >= WE_HIGH,
          "R4 write pulse shape", minWeLow * 1000 + minWeHigh, WE_LOW * 1000 + WE_HIGH);
    check(holdBad == 0, "R5 address and data hold", holdBad, 0);
    check(maxFallGap < LOAD_LIM, "R6 load window", maxFallGap, LOAD_LIM - 1);
    check(rdAddrBad == 0, "R7 read at last written address", rdAddrBad, 0);
    check(minOeHigh >= OE_HIGH, "R8 OE high before read", minOeHigh, OE_HIGH);
    @(negedge clk);
    check(!done && !error && memCsN && memOeN && memWeN && !fetchReq,
          "R1 R9 idle after single pulse", {done, error, memCsN, memOeN, memWeN}, 7);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(memCsN && memOeN && memWeN && !done && !error && !fetchReq && !busy,
          "R1 reset state", {memCsN, memOeN, memWeN, done, error}, 28);
    rstN = 1;
    runOp(10'h155, 1,   0, 0, -1, 0);   // single byte, ready immediately
    runOp(10'h3FF, 128, 0, 5, -1, 3);   // full page
    runOp(10'h001, 4,   1, 0, -1, 2);   // toggle with no busy reads
    runOp(10'h0AA, 6,   1, 3, -1, 1);   // toggle, odd busy count
    runOp(10'h2C3, 6,   1, 4, -1, 1);   // toggle, even busy count
    runOp(10'h111, 10,  0, 2, 4, 0);    // R6 buffer stalls at byte 4
    runOp(10'h222, 10,  1, 2, 1, 0);    // R6 stall after first byte
    runOp(10'h0F0, 2,   0, NEVER, -1, 0); // R9 never completes
    for (int n = 0; n < 8; n++)
      runOp(10'($urandom), $urandom_range(1, 128), 1'($urandom), $urandom_range(0, 6), -1,
            $urandom_range(0, 4));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule